// File: doc/BRIEF.md
# DDR4 Command Decoder and Bank Timing Checker

This block sits beside a DDR4-style memory device and samples its command/address pins once per command clock. It turns each sample into a command code. It reports the addressed bank, the row or column, and the auto-precharge and burst-chop qualifiers. It also keeps a model of 16 banks, arranged as 4 bank groups of 4 banks, so that it can flag any command that breaks the protocol or a timing rule.

The timing limits are the activate-to-column delay, the precharge-to-activate delay, the same-group and any-group column spacing, and the read latency. They are sampled from configuration inputs while reset is held and stay fixed until the next reset.

A command that is flagged is reported but never changes the bank model, so a single bad command does not hide the checks that follow. Every accepted read also produces a one-cycle "data due" pulse, placed where the read data should appear.

Top module: `ddr_cmd_watch`

## Requirements
- R1: With cs_n high the cycle is a deselect. The outputs show command code 0 with bank, row/column, flags and violation all zero. The other pins are ignored and the bank model does not change.
- R2: With cs_n low and act_n low the command is activate (code 2). rowcol_o carries the 18-bit row {ras_n, cas_n, we_n, addr[14:0]}, and bank_o is {bg, ba}.
- R3: With act_n high, {ras_n,cas_n,we_n} decodes as follows: 111 no-op (1), 101 read (3), 100 write (4), 001 refresh (7), 000 mode-register set (8). For mode-register set, bank_o = {bg,ba} names the register.
- R4: addr[10] selects the command variant. On read and write it appears on ap_o (auto-precharge). With 010 it gives precharge-all (6) when set and single-bank precharge (5) when clear. With 110 it gives long ZQ calibration (9) when set and short ZQ calibration (10) when clear. For read and write, rowcol_o = addr[9:0].
- R5: For read and write, bc_o = addr[12]. Every accepted column command keeps its bank busy for 4 clocks whether or not it is chopped. A column command to that bank during the next 3 cycles gets reason 5, while other banks are still accepted.
- R6: Pins 011 decode as reserved (code 11) with reason 1. A read or write to a closed bank gets reason 2. An activate to an open bank gets reason 3.
- R7: A read or write issued fewer than tRCD cycles after the activate of its bank gets reason 4.
- R8: An activate issued fewer than tRP cycles after a precharge that covers its bank gets reason 8. Precharge-all covers all 16 banks.
- R9: A column command with auto-precharge closes its bank 4 cycles after issue. tRP is counted from that cycle.
- R10: A column command fewer than tCCD_L cycles after the previous accepted column command in the same bank group gets reason 6. Otherwise, one fewer than tCCD_S cycles after any accepted column command gets reason 7.
- R11: rd_due_o pulses for one cycle exactly CL cycles after an accepted read. CL is clamped into 10..24 when it is sampled.
- R12: Reasons are checked in priority order. For activate: open, then tRP. For column commands: closed, then tRCD, then busy, then same-group spacing, then any-group spacing. viol_o is high exactly when viol_code_o is non-zero. A flagged command does not change the bank model.
- R13: All decoded outputs are registered and appear one cycle after the sample. The timing configuration is sampled while rst_n is low, and during reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous active-low reset; timing configuration is sampled while low |
| cfg_trcd | input | 6 | Activate-to-column delay in cycles |
| cfg_trp | input | 6 | Precharge-to-activate delay in cycles |
| cfg_tccd_l | input | 6 | Column spacing within one bank group |
| cfg_tccd_s | input | 6 | Column spacing between any two column commands |
| cfg_cl | input | 5 | Read latency (clamped to 10..24) |
| cs_n | input | 1 | Chip select, active low |
| act_n | input | 1 | Activate strobe, active low |
| ras_n | input | 1 | Command bit / row bit 17 |
| cas_n | input | 1 | Command bit / row bit 16 |
| we_n | input | 1 | Command bit / row bit 15 |
| bg | input | 2 | Bank group |
| ba | input | 2 | Bank within the group |
| addr | input | 15 | Address lines |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 4 | {bg, ba} of the command |
| rowcol_o | output | 18 | Row for activate, column for read/write |
| ap_o | output | 1 | Auto-precharge requested |
| bc_o | output | 1 | Burst chop requested |
| viol_o | output | 1 | Command broke a rule |
| viol_code_o | output | 4 | Reason code, 0 when none |
| rd_due_o | output | 1 | Read data expected this cycle |

## Verification
The embedded assertions check the following on every cycle:
- no column command reaches a bank that is closed, still inside tRCD, or busy;
- no activate reaches a bank that is open or inside tRP;
- a pending auto-precharge always belongs to an open bank;
- accepted column commands respect both spacing limits;
- a deselect leaves the outputs quiet.

The bench shows the rest:
- the decode values for each command;
- the priority among reasons;
- the exact cycle where an auto-precharge closes a bank and starts tRP;
- the position of the read-data pulse under two latencies, one of which needs clamping.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;

  typedef enum logic [3:0] {
    CMD_DES  = 4'd0,
    CMD_NOP  = 4'd1,
    CMD_ACT  = 4'd2,
    CMD_RD   = 4'd3,
    CMD_WR   = 4'd4,
    CMD_PRE  = 4'd5,
    CMD_PREA = 4'd6,
    CMD_REF  = 4'd7,
    CMD_MRS  = 4'd8,
    CMD_ZQL  = 4'd9,
    CMD_ZQS  = 4'd10,
    CMD_RSVD = 4'd11
  } cmd_e;

  typedef enum logic [3:0] {
    VR_NONE   = 4'd0,
    VR_RSVD   = 4'd1,
    VR_CLOSED = 4'd2,
    VR_OPEN   = 4'd3,
    VR_TRCD   = 4'd4,
    VR_BUSY   = 4'd5,
    VR_CCDL   = 4'd6,
    VR_CCDS   = 4'd7,
    VR_TRP    = 4'd8
  } vr_e;

  // Command table for a selected cycle (act_n low wins over the others).
  function automatic cmd_e decode_cmd(input logic act_n, input logic ras_n,
                                      input logic cas_n, input logic we_n,
                                      input logic a10);
    if (!act_n) return CMD_ACT;
    case ({ras_n, cas_n, we_n})
      3'b111:  return CMD_NOP;
      3'b110:  return a10 ? CMD_ZQL : CMD_ZQS;
      3'b101:  return CMD_RD;
      3'b100:  return CMD_WR;
      3'b010:  return a10 ? CMD_PREA : CMD_PRE;
      3'b001:  return CMD_REF;
      3'b000:  return CMD_MRS;
      default: return CMD_RSVD;
    endcase
  endfunction

  // Countdown preset so that the counter reaches zero exactly v cycles later.
  function automatic int unsigned down_preset(input int unsigned v);
    return (v == 0) ? 0 : v - 1;
  endfunction

  function automatic int unsigned clamp_lat(input int unsigned v,
                                            input int unsigned lo,
                                            input int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/ddrw_decode.sv
module ddrw_decode
  import ddrw_pkg::*;
#(
  parameter int AW     = 15,
  parameter int BGW    = 2,
  parameter int BAW    = 2,
  parameter int COLW   = 10,
  parameter int AP_BIT = 10,
  parameter int BC_BIT = 12,
  localparam int BKW   = BGW + BAW,
  localparam int ROWW  = AW + 3
) (
  input  logic            cs_n,
  input  logic            act_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BGW-1:0]  bg,
  input  logic [BAW-1:0]  ba,
  input  logic [AW-1:0]   addr,
  output cmd_e            cmd,
  output logic [BKW-1:0]  bank,
  output logic [ROWW-1:0] rowcol,
  output logic            ap,
  output logic            bc
);

  always_comb begin
    cmd    = CMD_DES;
    bank   = '0;
    rowcol = '0;
    ap     = 1'b0;
    bc     = 1'b0;
    if (!cs_n) begin
      cmd  = decode_cmd(act_n, ras_n, cas_n, we_n, addr[AP_BIT]);
      bank = {bg, ba};
      case (cmd)
        CMD_ACT: rowcol = {ras_n, cas_n, we_n, addr};
        CMD_RD, CMD_WR: begin
          rowcol = ROWW'(addr[COLW-1:0]);
          ap     = addr[AP_BIT];
          bc     = addr[BC_BIT];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ddrw_bank.sv
module ddrw_bank
  import ddrw_pkg::*;
#(
  parameter int TW       = 6,
  parameter int BUSY_CLK = 4,
  localparam int BW      = $clog2(BUSY_CLK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cfg_rcd,
  input  logic [TW-1:0] cfg_rp,
  input  logic          act_go,
  input  logic          col_go,
  input  logic          col_ap,
  input  logic          pre_go,
  output logic          is_open,
  output logic          rcd_wait,
  output logic          rp_wait,
  output logic          busy
);

  logic          open_q;
  logic          ap_q;
  logic [TW-1:0] rcd_q;
  logic [TW-1:0] rp_q;
  logic [BW-1:0] busy_q;
  logic          ap_close;   // burst end of an auto-precharged access

  assign ap_close = ap_q && (busy_q == BW'(1));
  assign is_open  = open_q;
  assign rcd_wait = (rcd_q != '0);
  assign rp_wait  = (rp_q != '0);
  assign busy     = (busy_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      ap_q   <= 1'b0;
      rcd_q  <= '0;
      rp_q   <= '0;
      busy_q <= '0;
    end else begin
      if (rcd_q != '0)  rcd_q  <= rcd_q - 1'b1;
      if (rp_q != '0)   rp_q   <= rp_q - 1'b1;
      if (busy_q != '0) busy_q <= busy_q - 1'b1;
      if (act_go) begin
        open_q <= 1'b1;
        rcd_q  <= TW'(down_preset(int'(cfg_rcd)));
      end
      if (col_go) begin
        busy_q <= BW'(BUSY_CLK - 1);
        ap_q   <= col_ap;
      end
      if (ap_close) begin
        // close happens one cycle before the count starts, hence no preset
        open_q <= 1'b0;
        ap_q   <= 1'b0;
        rp_q   <= cfg_rp;
      end
      if (pre_go) begin
        open_q <= 1'b0;
        ap_q   <= 1'b0;
        rp_q   <= TW'(down_preset(int'(cfg_rp)));
      end
    end
  end

  AST_COL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    col_go |-> open_q); // R6
  AST_RCD_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    col_go |-> (rcd_q == '0)); // R7
  AST_RP_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |-> (rp_q == '0 && !open_q)); // R8
  AST_AP_PENDING_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ap_q |-> open_q); // R9
  AST_NO_COL_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    col_go |-> (busy_q == '0)); // R5

endmodule

// File: rtl/ddrw_spacing.sv
module ddrw_spacing #(
  parameter int TW  = 6,
  parameter int BGW = 2,
  localparam int NG = 1 << BGW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           col_go,
  input  logic [BGW-1:0] grp,
  input  logic [TW-1:0]  cfg_l,
  input  logic [TW-1:0]  cfg_s,
  output logic           short_l,
  output logic           short_s
);

  localparam logic [TW-1:0] GAP_MAX = {TW{1'b1}};

  logic [TW-1:0]         gap_all;
  logic [NG-1:0][TW-1:0] gap_g;

  function automatic logic [TW-1:0] sat_inc(input logic [TW-1:0] v);
    return (v == GAP_MAX) ? v : v + 1'b1;
  endfunction

  assign short_l = (gap_g[grp] < cfg_l);
  assign short_s = (gap_all < cfg_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_all <= GAP_MAX;
      for (int g = 0; g < NG; g++) gap_g[g] <= GAP_MAX;
    end else begin
      gap_all <= col_go ? TW'(1) : sat_inc(gap_all);
      for (int g = 0; g < NG; g++)
        gap_g[g] <= (col_go && grp == BGW'(g)) ? TW'(1) : sat_inc(gap_g[g]);
    end
  end

  AST_SAME_GROUP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    col_go |-> (gap_g[grp] >= cfg_l)); // R10
  AST_ANY_GROUP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    col_go |-> (gap_all >= cfg_s)); // R10

endmodule

// File: rtl/ddr_cmd_watch.sv
module ddr_cmd_watch
  import ddrw_pkg::*;
#(
  parameter int AW       = 15,
  parameter int BGW      = 2,
  parameter int BAW      = 2,
  parameter int COLW     = 10,
  parameter int TW       = 6,
  parameter int CLW      = 5,
  parameter int CL_MIN   = 10,
  parameter int CL_MAX   = 24,
  parameter int BUSY_CLK = 4,
  parameter int AP_BIT   = 10,
  parameter int BC_BIT   = 12,
  localparam int BKW     = BGW + BAW,
  localparam int NB      = 1 << BKW,
  localparam int ROWW    = AW + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW-1:0]   cfg_trcd,
  input  logic [TW-1:0]   cfg_trp,
  input  logic [TW-1:0]   cfg_tccd_l,
  input  logic [TW-1:0]   cfg_tccd_s,
  input  logic [CLW-1:0]  cfg_cl,
  input  logic            cs_n,
  input  logic            act_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BGW-1:0]  bg,
  input  logic [BAW-1:0]  ba,
  input  logic [AW-1:0]   addr,
  output logic [3:0]      cmd_o,
  output logic [BKW-1:0]  bank_o,
  output logic [ROWW-1:0] rowcol_o,
  output logic            ap_o,
  output logic            bc_o,
  output logic            viol_o,
  output logic [3:0]      viol_code_o,
  output logic            rd_due_o
);

  // Timing configuration, sampled while reset is held.
  logic [TW-1:0]  rcd_q, rp_q, ccdl_q, ccds_q;
  logic [CLW-1:0] cl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcd_q  <= cfg_trcd;
      rp_q   <= cfg_trp;
      ccdl_q <= cfg_tccd_l;
      ccds_q <= cfg_tccd_s;
      cl_q   <= CLW'(clamp_lat(int'(cfg_cl), CL_MIN, CL_MAX));
    end
  end

  cmd_e            dec_cmd;
  logic [BKW-1:0]  dec_bank;
  logic [ROWW-1:0] dec_rowcol;
  logic            dec_ap, dec_bc;

  ddrw_decode #(.AW(AW), .BGW(BGW), .BAW(BAW), .COLW(COLW),
                .AP_BIT(AP_BIT), .BC_BIT(BC_BIT)) u_decode (
    .cs_n(cs_n), .act_n(act_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .bg(bg), .ba(ba), .addr(addr),
    .cmd(dec_cmd), .bank(dec_bank), .rowcol(dec_rowcol), .ap(dec_ap), .bc(dec_bc)
  );

  // Named events for the assertions and the bank trackers.
  logic [NB-1:0] bk_open, bk_rcd, bk_rp, bk_busy;
  logic          is_col, short_l, short_s;
  vr_e           vr;
  logic          accept, act_ok, col_ok, rd_ok, pre_one, pre_all;

  assign is_col = (dec_cmd == CMD_RD) || (dec_cmd == CMD_WR);

  always_comb begin
    vr = VR_NONE;
    case (dec_cmd)
      CMD_RSVD: vr = VR_RSVD;
      CMD_ACT: begin
        if (bk_open[dec_bank])    vr = VR_OPEN;
        else if (bk_rp[dec_bank]) vr = VR_TRP;
      end
      CMD_RD, CMD_WR: begin
        if (!bk_open[dec_bank])     vr = VR_CLOSED;
        else if (bk_rcd[dec_bank])  vr = VR_TRCD;
        else if (bk_busy[dec_bank]) vr = VR_BUSY;
        else if (short_l)           vr = VR_CCDL;
        else if (short_s)           vr = VR_CCDS;
      end
      default: ;
    endcase
  end

  assign accept  = (vr == VR_NONE);
  assign act_ok  = accept && (dec_cmd == CMD_ACT);
  assign col_ok  = accept && is_col;
  assign rd_ok   = accept && (dec_cmd == CMD_RD);
  assign pre_one = (dec_cmd == CMD_PRE);
  assign pre_all = (dec_cmd == CMD_PREA);

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic hit;
    assign hit = (dec_bank == BKW'(i));
    ddrw_bank #(.TW(TW), .BUSY_CLK(BUSY_CLK)) u_bank (
      .clk(clk), .rst_n(rst_n), .cfg_rcd(rcd_q), .cfg_rp(rp_q),
      .act_go(act_ok && hit), .col_go(col_ok && hit), .col_ap(dec_ap),
      .pre_go(pre_all || (pre_one && hit)),
      .is_open(bk_open[i]), .rcd_wait(bk_rcd[i]), .rp_wait(bk_rp[i]),
      .busy(bk_busy[i])
    );
  end

  ddrw_spacing #(.TW(TW), .BGW(BGW)) u_spacing (
    .clk(clk), .rst_n(rst_n), .col_go(col_ok), .grp(dec_bank[BKW-1 -: BGW]),
    .cfg_l(ccdl_q), .cfg_s(ccds_q), .short_l(short_l), .short_s(short_s)
  );

  // Read-data timeline: bit k set means data is due k cycles from now.
  logic [CL_MAX:0] due_q;

  always_ff @(posedge clk) begin
    if (!rst_n) due_q <= '0;
    else due_q <= (due_q >> 1) | (rd_ok ? ((CL_MAX+1)'(1) << cl_q) : '0);
  end

  assign rd_due_o = due_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_o       <= '0;
      bank_o      <= '0;
      rowcol_o    <= '0;
      ap_o        <= 1'b0;
      bc_o        <= 1'b0;
      viol_o      <= 1'b0;
      viol_code_o <= '0;
    end else begin
      cmd_o       <= dec_cmd;
      bank_o      <= dec_bank;
      rowcol_o    <= dec_rowcol;
      ap_o        <= dec_ap;
      bc_o        <= dec_bc;
      viol_o      <= !accept;
      viol_code_o <= vr;
    end
  end

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> (cmd_o == CMD_DES && !viol_o)); // R1
  AST_FLAG_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o == (viol_code_o != VR_NONE)); // R12

endmodule

// File: tb/tb_ddr_cmd_watch.sv
`timescale 1ns/1ps
module tb_ddr_cmd_watch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_trcd = 6'd3, cfg_trp = 6'd4, cfg_tccd_l = 6'd4, cfg_tccd_s = 6'd2;
  logic [4:0]  cfg_cl = 5'd10;
  logic        cs_n = 1'b1, act_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  bg = '0, ba = '0;
  logic [14:0] addr = '0;
  logic [3:0]  cmd_o, bank_o, viol_code_o;
  logic [17:0] rowcol_o;
  logic        ap_o, bc_o, viol_o, rd_due_o;

  ddr_cmd_watch dut (
    .clk(clk), .rst_n(rst_n), .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp),
    .cfg_tccd_l(cfg_tccd_l), .cfg_tccd_s(cfg_tccd_s), .cfg_cl(cfg_cl),
    .cs_n(cs_n), .act_n(act_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .bg(bg), .ba(ba), .addr(addr), .cmd_o(cmd_o), .bank_o(bank_o),
    .rowcol_o(rowcol_o), .ap_o(ap_o), .bc_o(bc_o), .viol_o(viol_o),
    .viol_code_o(viol_code_o), .rd_due_o(rd_due_o)
  );

  always #2.5 clk = ~clk;   // 200 MHz

  int errors = 0, checks = 0;
  bit finished = 0;

  // ---------------- reference model state (time stamps) ----------------
  int cyc;
  int m_rcd, m_rp, m_l, m_s, m_cl;
  bit m_open[16];
  int m_act_t[16], m_pre_t[16], m_busy_u[16], m_ap_at[16];
  int m_last, m_last_g[4];
  int due_q[$];
  int seen[9];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  function automatic string vtag(input int v);
    case (v)
      1, 2, 3: return "R6";
      4:       return "R7";
      5:       return "R5";
      6, 7:    return "R10";
      8:       return "R8";
      default: return "R12";
    endcase
  endfunction

  function automatic string ctag(input int c);
    case (c)
      0:        return "R1";
      2:        return "R2";
      5, 6, 9, 10: return "R4";
      11:       return "R6";
      default:  return "R3";
    endcase
  endfunction

  task automatic model_reset(input int trcd, trp, tl, ts, cl);
    m_rcd = trcd; m_rp = trp; m_l = tl; m_s = ts;
    m_cl = (cl < 10) ? 10 : (cl > 24) ? 24 : cl;   // R11 clamp
    for (int b = 0; b < 16; b++) begin
      m_open[b] = 0; m_act_t[b] = -1000; m_pre_t[b] = -1000;
      m_busy_u[b] = 0; m_ap_at[b] = -1;
    end
    m_last = -1000;
    for (int g = 0; g < 4; g++) m_last_g[g] = -1000;
    due_q.delete();
    cyc = 0;
  endtask

  // One command cycle: drive at negedge, model at posedge, compare at next negedge (R13).
  task automatic step(input logic c, a, r, ca, w, input logic [1:0] g, b,
                      input logic [14:0] ad);
    int ec, ev, er, eb, ea, ebc, k, ed;
    cs_n = c; act_n = a; ras_n = r; cas_n = ca; we_n = w; bg = g; ba = b; addr = ad;
    @(posedge clk);
    for (int i = 0; i < 16; i++)
      if (m_ap_at[i] >= 0 && cyc >= m_ap_at[i]) begin   // R9 close at burst end
        m_open[i] = 0; m_pre_t[i] = m_ap_at[i]; m_ap_at[i] = -1;
      end
    if (c) ec = 0;
    else if (!a) ec = 2;
    else case ({r, ca, w})
      3'b111: ec = 1;
      3'b110: ec = ad[10] ? 9 : 10;
      3'b101: ec = 3;
      3'b100: ec = 4;
      3'b010: ec = ad[10] ? 6 : 5;
      3'b001: ec = 7;
      3'b000: ec = 8;
      default: ec = 11;
    endcase
    k = {g, b};
    eb = c ? 0 : k;
    er = 0; ea = 0; ebc = 0;
    if (ec == 2) er = {r, ca, w, ad};
    if (ec == 3 || ec == 4) begin er = ad[9:0]; ea = ad[10]; ebc = ad[12]; end
    ev = 0;
    if (ec == 11) ev = 1;
    else if (ec == 2) begin
      if (m_open[k]) ev = 3;
      else if (cyc - m_pre_t[k] < m_rp) ev = 8;
    end else if (ec == 3 || ec == 4) begin
      if (!m_open[k]) ev = 2;
      else if (cyc - m_act_t[k] < m_rcd) ev = 4;
      else if (cyc < m_busy_u[k]) ev = 5;
      else if (cyc - m_last_g[g] < m_l) ev = 6;
      else if (cyc - m_last < m_s) ev = 7;
    end
    seen[ev]++;
    if (ev == 0) begin   // R12: only accepted commands touch the model
      if (ec == 2) begin m_open[k] = 1; m_act_t[k] = cyc; end
      if (ec == 3 || ec == 4) begin
        m_busy_u[k] = cyc + 4;
        if (ad[10]) m_ap_at[k] = cyc + 4;
        m_last = cyc; m_last_g[g] = cyc;
        if (ec == 3) due_q.push_back(cyc + m_cl);
      end
      if (ec == 5) begin m_open[k] = 0; m_ap_at[k] = -1; m_pre_t[k] = cyc; end
      if (ec == 6)
        for (int i = 0; i < 16; i++) begin m_open[i] = 0; m_ap_at[i] = -1; m_pre_t[i] = cyc; end
    end
    ed = 0;
    for (int i = due_q.size() - 1; i >= 0; i--)
      if (due_q[i] == cyc) begin ed = 1; due_q.delete(i); end
    @(negedge clk);
    chk(ctag(ec), "cmd_o", cmd_o, ec);
    chk("R3", "bank_o", bank_o, eb);
    chk((ec == 2) ? "R2" : "R4", "rowcol_o", rowcol_o, er);
    chk("R4", "ap_o", ap_o, ea);
    chk("R5", "bc_o", bc_o, ebc);
    chk(vtag(ev), "viol_code_o", viol_code_o, ev);
    chk("R12", "viol_o", viol_o, ev != 0);
    chk("R11", "rd_due_o", rd_due_o, ed);
    cyc++;
  endtask

  task automatic nop();                 step(0, 1, 1, 1, 1, 0, 0, 0); endtask
  task automatic idle(input int n);     repeat (n) nop(); endtask
  task automatic act(input logic [1:0] g, b, input logic [17:0] row);
    step(0, 0, row[17], row[16], row[15], g, b, row[14:0]);
  endtask
  task automatic col(input logic wr, input logic [1:0] g, b, input int c,
                     input logic ap, input logic bc);
    logic [14:0] ad;
    ad = 15'(c & 10'h3ff);
    ad[10] = ap; ad[12] = bc;
    step(0, 1, 1, 0, ~wr, g, b, ad);
  endtask
  task automatic pre(input logic [1:0] g, b); step(0, 1, 0, 1, 0, g, b, 0); endtask
  task automatic prea();                     step(0, 1, 0, 1, 0, 0, 0, 15'h0400); endtask

  task automatic do_reset(input int trcd, trp, tl, ts, cl);
    cfg_trcd = 6'(trcd); cfg_trp = 6'(trp); cfg_tccd_l = 6'(tl);
    cfg_tccd_s = 6'(ts); cfg_cl = 5'(cl);
    rst_n = 0; cs_n = 1;
    repeat (3) @(negedge clk);
    // R13: reset state
    chk("R13", "cmd_o in reset", cmd_o, 0);
    chk("R13", "viol_o in reset", viol_o, 0);
    chk("R13", "rd_due_o in reset", rd_due_o, 0);
    chk("R13", "rowcol_o in reset", rowcol_o, 0);
    rst_n = 1;
    model_reset(trcd, trp, tl, ts, cl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // Phase 1: tRCD=3 tRP=4 tCCD_L=4 tCCD_S=2 CL=10
    do_reset(3, 4, 4, 2, 10);
    act(0, 0, 18'h2_a5a5);        // c0 R2 high row bits from ras/cas/we
    col(0, 0, 0, 5, 0, 0);        // c1 R7 too soon
    act(0, 0, 18'h00001);         // c2 R6 already open
    col(0, 0, 0, 7, 0, 1);        // c3 chopped read accepted (R5)
    act(1, 1, 18'h3_ffff);        // c4 other bank opens while b0 busy (R5)
    col(0, 0, 0, 9, 0, 0);        // c5 R5 busy
    step(1, 0, 0, 0, 0, 3, 3, 15'h7fff); // c6 R1 deselect ignores pins
    col(0, 0, 0, 11, 0, 0);       // c7 accepted read
    col(1, 1, 1, 3, 0, 0);        // c8 R10 any-group spacing
    col(1, 1, 1, 4, 0, 1);        // c9 accepted write
    col(0, 0, 1, 1, 0, 0);        // c10 R6 closed bank
    act(0, 1, 18'h00100);         // c11
    pre(0, 0);                    // c12
    act(0, 0, 18'h00002);         // c13 R8 tRP
    col(0, 0, 1, 2, 1, 0);        // c14 read with auto-precharge (R9)
    step(0, 1, 0, 1, 1, 0, 0, 0); // c15 R6 reserved
    act(0, 0, 18'h00003);         // c16
    step(0, 1, 0, 0, 0, 1, 2, 15'h0123); // c17 R3 mode-register set
    act(0, 1, 18'h00004);         // c18 R9 closed but tRP from burst end
    col(0, 0, 1, 3, 0, 0);        // c19 R9 bank now closed
    step(0, 1, 1, 1, 0, 0, 0, 15'h0400); // c20 R4 ZQ long
    step(0, 1, 1, 1, 0, 0, 0, 15'h0000); // c21 R4 ZQ short
    step(0, 1, 0, 0, 1, 0, 0, 0); // c22 R3 refresh
    act(0, 1, 18'h00005);         // c23 tRP met after auto-precharge
    prea();                       // c24 R4 precharge-all
    col(0, 1, 1, 0, 0, 0);        // c25 R8 all closed
    idle(2);
    act(2, 0, 18'h00010);         // c28
    act(2, 1, 18'h00011);         // c29
    idle(2);
    col(0, 2, 0, 1, 0, 0);        // c32
    nop();
    col(0, 2, 1, 1, 0, 0);        // c34 R10 same-group spacing
    nop();
    col(0, 2, 1, 2, 0, 0);        // c36 accepted
    col(1, 3, 0, 2, 0, 0);        // c37 closed
    idle(30);
    // Phase 2: tRCD=2 tRP=2 tCCD_L=2 tCCD_S=1 CL=31 (clamped to 24, R11)
    do_reset(2, 2, 2, 1, 31);
    act(3, 3, 18'h3_ffff);        // c0
    nop();
    col(0, 3, 3, 1, 0, 0);        // c2 read due at 26
    col(0, 3, 3, 2, 0, 0);        // c3 busy
    idle(2);
    col(0, 3, 3, 3, 1, 1);        // c6 chopped read with auto-precharge, due 30
    idle(3);
    act(3, 3, 18'h1);             // c10 R8 inside tRP after auto-precharge
    nop();
    act(3, 3, 18'h2);             // c12 accepted
    idle(30);
    // Coverage of every reason code (R12 ordering exercised above)
    for (int v = 1; v <= 8; v++) begin
      checks++;
      if (seen[v] == 0) begin
        errors++;
        $display("FAIL %s reason %0d never exercised: actual=0 expected>0", vtag(v), v);
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule